// File: doc/BRIEF.md
# Protected Memory Size Query Register

This block is the part of a memory controller's configuration space that lets boot firmware find and pick the size of the protected system-management memory region. It holds two things. The first is a 16-bit query register. The second is a 2-bit size-select field. It also outputs the chosen region size in bytes for the address decoder that follows it. The extended size is fixed at build time by the parameter `EXT_MB`, given in megabytes.

To query the size, firmware writes the all-ones pattern to the query register. It then reads the register back. If an extended size is configured, the read returns that size in megabytes. If no extended size is configured (`EXT_MB = 0`), the register acts as ordinary storage. Firmware can then select the extended size with the size code that has no fixed meaning. The three other codes keep their fixed sizes.

Top module: `smram_size_cfg`

## Requirements
- R1: On reset the query register holds `EXT_MB`, which is 0 in legacy mode. The size-select field resets to code 00 and the size output to 0x0010_0000.
- R2: With `EXT_MB` nonzero, a write that leaves the query register at 0xFFFF makes the next read of it return `EXT_MB` instead.
- R3: With `EXT_MB` equal to 0, writing 0xFFFF stores 0xFFFF, and a read returns 0xFFFF.
- R4: Any other value written to the query register is stored unchanged and read back as written.
- R5: `cfg_be[0]` updates bits 7:0 and `cfg_be[1]` updates bits 15:8. Bytes that are not enabled keep their old value. The 0xFFFF test is made on the merged 16-bit result, and a write with no enables changes nothing.
- R6: Size code 00 gives a size output of 0x0010_0000, code 01 gives 0x0020_0000, and code 10 gives 0x0080_0000.
- R7: Size code 11 gives `EXT_MB` shifted left by 20 when `EXT_MB` is nonzero, and 0 in legacy mode.
- R8: The query register is at byte offset 0x50 (word 0x50/0x51). The size code is in bits 1:0 at offset 0x54 and is written when `cfg_be[0]` is set. Reads of any other offset return 0, and writes to any other offset change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe, sampled on the rising edge |
| cfg_addr | input | 8 | Byte offset of the even-aligned 16-bit word |
| cfg_be | input | 2 | Byte enables, bit 0 for the low byte |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data for `cfg_addr` (combinational) |
| region_bytes | output | 32 | Decoded protected-region size in bytes |

## Verification
The bench builds three copies of the block side by side, all driven by one bus. The first uses the default `EXT_MB = 16`, the second `EXT_MB = 0`, and the third `EXT_MB = 4095`. Together they show the arming write in its converted form and in its legacy store-as-is form from the same stimulus. The 4095 copy checks that code 11 reaches the top of the 32-bit size range, 0xFFF0_0000. It also checks that a reset reload gives a value different from the legacy zero.

// File: rtl/smq_pkg.sv
package smq_pkg;

   typedef enum logic [1:0] {
      SZ_1MB = 2'b00,
      SZ_2MB = 2'b01,
      SZ_8MB = 2'b10,
      SZ_EXT = 2'b11
   } smq_code_e;

   localparam int MB_SHIFT   = 20;
   localparam int EXT_MB_MAX = 4095;

endpackage

// File: rtl/smq_query_reg.sv
module smq_query_reg #(
   parameter int QW     = 16,
   parameter int EXT_MB = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_hit,
   input  logic [QW/8-1:0] be,
   input  logic [QW-1:0]   wdata,
   output logic [QW-1:0]   q
);
   localparam int          NB      = QW / 8;
   localparam logic [QW-1:0] ARM   = '1;
   localparam logic [QW-1:0] EXT_V = QW'(EXT_MB);

   logic [QW-1:0] merged;
   logic [QW-1:0] nxt;

   for (genvar b = 0; b < NB; b++) begin : g_lane
      assign merged[8*b +: 8] = be[b] ? wdata[8*b +: 8] : q[8*b +: 8];
   end

   if (EXT_MB != 0) begin : g_ext
      assign nxt = (merged == ARM) ? EXT_V : merged;
   end else begin : g_legacy
      assign nxt = merged;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= EXT_V;
      else if (wr_hit) q <= nxt;
   end
endmodule

// File: rtl/smq_code_reg.sv
module smq_code_reg #(
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_hit,
   input  logic [CW-1:0] wdata,
   output logic [CW-1:0] code
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      code <= '0;
      else if (wr_hit) code <= wdata;
   end
endmodule

// File: rtl/smq_size_decode.sv
module smq_size_decode
   import smq_pkg::*;
#(
   parameter int EXT_MB = 16,
   parameter int SIZE_W = 32
) (
   input  logic [1:0]        code,
   output logic [SIZE_W-1:0] size_bytes
);
   localparam logic [SIZE_W-1:0] ONE_MB = SIZE_W'(1) << MB_SHIFT;
   logic [SIZE_W-1:0] ext_bytes;

   if (EXT_MB != 0) begin : g_ext
      assign ext_bytes = SIZE_W'(EXT_MB) << MB_SHIFT;
   end else begin : g_legacy
      assign ext_bytes = '0;
   end

   always_comb begin
      unique case (smq_code_e'(code))
         SZ_1MB:  size_bytes = ONE_MB;
         SZ_2MB:  size_bytes = ONE_MB << 1;
         SZ_8MB:  size_bytes = ONE_MB << 3;
         default: size_bytes = ext_bytes;
      endcase
   end
endmodule

// File: rtl/smram_size_cfg.sv
module smram_size_cfg
   import smq_pkg::*;
#(
   parameter int                EXT_MB   = 16,
   parameter int                ADDR_W   = 8,
   parameter int                DATA_W   = 16,
   parameter int                SIZE_W   = 32,
   parameter logic [ADDR_W-1:0] QRY_OFS  = 8'h50,
   parameter logic [ADDR_W-1:0] CODE_OFS = 8'h54
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [ADDR_W-1:0]   cfg_addr,
   input  logic [DATA_W/8-1:0] cfg_be,
   input  logic [DATA_W-1:0]   cfg_wdata,
   output logic [DATA_W-1:0]   cfg_rdata,
   output logic [SIZE_W-1:0]   region_bytes
);
   localparam int CW = 2;

   if (EXT_MB < 0 || EXT_MB > EXT_MB_MAX) begin : g_bad_ext
      $error("EXT_MB must lie in 0..4095");
   end
   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_w
      $error("DATA_W must be a byte multiple of at least 16");
   end
   if (SIZE_W < 32) begin : g_bad_sz
      $error("SIZE_W must be at least 32");
   end
   if (QRY_OFS[0] || CODE_OFS[0] || QRY_OFS == CODE_OFS) begin : g_bad_ofs
      $error("register offsets must be even and distinct");
   end

   logic              qry_hit, code_hit;
   logic [DATA_W-1:0] qry_q;
   logic [CW-1:0]     code_q;

   assign qry_hit  = cfg_we && (cfg_addr == QRY_OFS);
   assign code_hit = cfg_we && (cfg_addr == CODE_OFS) && cfg_be[0];

   smq_query_reg #(.QW(DATA_W), .EXT_MB(EXT_MB)) u_qry (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (qry_hit),
      .be     (cfg_be),
      .wdata  (cfg_wdata),
      .q      (qry_q)
   );

   smq_code_reg #(.CW(CW)) u_code (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (code_hit),
      .wdata  (cfg_wdata[CW-1:0]),
      .code   (code_q)
   );

   smq_size_decode #(.EXT_MB(EXT_MB), .SIZE_W(SIZE_W)) u_dec (
      .code       (code_q),
      .size_bytes (region_bytes)
   );

   always_comb begin
      if (cfg_addr == QRY_OFS)       cfg_rdata = qry_q;
      else if (cfg_addr == CODE_OFS) cfg_rdata = DATA_W'(code_q);
      else                           cfg_rdata = '0;
   end
endmodule

// File: rtl/smq_checker.sv
module smq_checker #(
   parameter int                EXT_MB   = 16,
   parameter int                ADDR_W   = 8,
   parameter int                DATA_W   = 16,
   parameter int                SIZE_W   = 32,
   parameter logic [ADDR_W-1:0] QRY_OFS  = 8'h50
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cfg_we,
   input logic [ADDR_W-1:0]   cfg_addr,
   input logic [DATA_W/8-1:0] cfg_be,
   input logic [DATA_W-1:0]   cfg_wdata,
   input logic [DATA_W-1:0]   cfg_rdata,
   input logic [DATA_W-1:0]   q_val,
   input logic [1:0]          code,
   input logic [SIZE_W-1:0]   region_bytes
);
   localparam logic [DATA_W-1:0] ARM   = '1;
   localparam logic [DATA_W-1:0] EXT_V = DATA_W'(EXT_MB);
   localparam logic [SIZE_W-1:0] EXT_B = (EXT_MB != 0) ? (SIZE_W'(EXT_MB) << 20) : '0;
   localparam logic [DATA_W/8-1:0] ALL_BE = '1;

   logic full_wr;
   assign full_wr = cfg_we && (cfg_addr == QRY_OFS) && (cfg_be == ALL_BE);

   AST_ARM_CONVERTS: assert property (@(posedge clk) disable iff (!rst_n)
      (EXT_MB != 0 && full_wr && cfg_wdata == ARM) |=> (q_val == EXT_V)); // R2
   AST_LEGACY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (EXT_MB == 0 && full_wr && cfg_wdata == ARM) |=> (q_val == ARM)); // R3
   AST_PLAIN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (full_wr && cfg_wdata != ARM) |=> (q_val == $past(cfg_wdata))); // R4
   AST_NO_BYTES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_be == '0) |=> $stable(q_val)); // R5
   AST_SIZE_8MB: assert property (@(posedge clk) disable iff (!rst_n)
      (code == 2'b10) |-> (region_bytes == SIZE_W'(32'h0080_0000))); // R6
   AST_SIZE_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (code == 2'b11) |-> (region_bytes == EXT_B)); // R7
   AST_QRY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr == QRY_OFS) |-> (cfg_rdata == q_val)); // R8
   AST_OTHER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && cfg_addr == QRY_OFS) |=> $stable(q_val)); // R8
endmodule

bind smram_size_cfg smq_checker #(
   .EXT_MB(EXT_MB), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .SIZE_W(SIZE_W), .QRY_OFS(QRY_OFS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_we       (cfg_we),
   .cfg_addr     (cfg_addr),
   .cfg_be       (cfg_be),
   .cfg_wdata    (cfg_wdata),
   .cfg_rdata    (cfg_rdata),
   .q_val        (qry_q),
   .code         (code_q),
   .region_bytes (region_bytes)
);

// File: tb/smram_size_cfg_bench.sv
module smram_size_cfg_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [1:0]  be = 2'b00;
   logic [15:0] wdata = 16'h0000;
   logic [15:0] rd_main, rd_leg, rd_max;
   logic [31:0] sz_main, sz_leg, sz_max;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   smram_size_cfg u_smram_size_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_addr(addr), .cfg_be(be),
      .cfg_wdata(wdata), .cfg_rdata(rd_main), .region_bytes(sz_main));
   smram_size_cfg #(.EXT_MB(0)) u_leg (
      .clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_addr(addr), .cfg_be(be),
      .cfg_wdata(wdata), .cfg_rdata(rd_leg), .region_bytes(sz_leg));
   smram_size_cfg #(.EXT_MB(4095)) u_max (
      .clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_addr(addr), .cfg_be(be),
      .cfg_wdata(wdata), .cfg_rdata(rd_max), .region_bytes(sz_max));

   // {addr, be, wdata, expected read of main copy at addr after the write}
   localparam int NV = 9;
   localparam logic [41:0] VEC [NV] = '{
      {8'h50, 2'b11, 16'h1234, 16'h1234},
      {8'h50, 2'b11, 16'hFFFF, 16'h0010},
      {8'h50, 2'b01, 16'h00AB, 16'h00AB},
      {8'h50, 2'b10, 16'hFF00, 16'hFFAB},
      {8'h50, 2'b01, 16'h00FF, 16'h0010},
      {8'h50, 2'b00, 16'h5555, 16'h0010},
      {8'h60, 2'b11, 16'hBEEF, 16'h0000},
      {8'h50, 2'b00, 16'h0000, 16'h0010},
      {8'h54, 2'b11, 16'h0002, 16'h0002}
   };

   function automatic string vtag(input int i);
      case (i)
         0:       return "R4";
         1:       return "R2";
         2, 3, 4: return "R5";
         5:       return "R5";
         default: return "R8";
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [1:0] b, input logic [15:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; be = b; wdata = d;
      @(negedge clk);
      we = 1'b0; be = 2'b00;
      #1;
   endtask

   task automatic rd_at(input logic [7:0] a);
      addr = a;
      #1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd_at(8'h50);
      check("R1 main query reset", 32'(rd_main), 32'h0010);
      check("R1 legacy query reset", 32'(rd_leg), 32'h0000);
      check("R1 max query reset", 32'(rd_max), 32'h0FFF);
      check("R1 size reset", sz_main, 32'h0010_0000);
      rd_at(8'h54);
      check("R1 code reset", 32'(rd_main), 32'h0000);

      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][41:34], VEC[i][33:32], VEC[i][31:16]);
         rd_at(VEC[i][41:34]);
         check(vtag(i), 32'(rd_main), 32'(VEC[i][15:0]));
      end
      rd_at(8'h50);
      check("R8 query after stray write", 32'(rd_main), 32'h0010);

      // size codes
      wr(8'h54, 2'b01, 16'h0000);
      check("R6 code00", sz_main, 32'h0010_0000);
      wr(8'h54, 2'b01, 16'h0001);
      check("R6 code01", sz_main, 32'h0020_0000);
      wr(8'h54, 2'b01, 16'h0002);
      check("R6 code10", sz_main, 32'h0080_0000);
      wr(8'h54, 2'b10, 16'h0003);
      check("R8 code needs low byte", sz_main, 32'h0080_0000);
      wr(8'h54, 2'b01, 16'h0003);
      check("R7 code11 main", sz_main, 32'h0100_0000);
      check("R7 code11 legacy", sz_leg, 32'h0000_0000);
      check("R7 code11 max", sz_max, 32'hFFF0_0000);

      // legacy vs extended arming
      wr(8'h50, 2'b11, 16'hFFFF);
      rd_at(8'h50);
      check("R3 legacy keeps ones", 32'(rd_leg), 32'hFFFF);
      check("R2 max converts", 32'(rd_max), 32'h0FFF);
      check("R2 main converts", 32'(rd_main), 32'h0010);
      wr(8'h50, 2'b11, 16'h0ABC);
      check("R4 legacy plain", 32'(rd_leg), 32'h0ABC);

      // reset reload
      wr(8'h50, 2'b11, 16'h1234);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd_at(8'h50);
      check("R1 reload main", 32'(rd_main), 32'h0010);
      check("R1 reload legacy", 32'(rd_leg), 32'h0000);
      check("R1 size after reset", sz_main, 32'h0010_0000);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule